// File: doc/BRIEF.md
# Framed Serial Sequence Checker

This block compares a serial bit stream, one bit per clock, against a fixed expected sequence of `SEQ_LEN` bits (100 by default). An external framing input marks which incoming bit is the first of a candidate sequence. The block therefore never searches a sliding window. It checks only the current bit against the head of a reference shift register. That register is loaded with the expected sequence when a frame starts and advances one place for every matching bit.

A bit that disagrees ends the attempt. The block then waits for the next frame marker. When every bit of the sequence has matched, a one-cycle match pulse is raised. A one-cycle mismatch pulse reports the first wrong bit of an active attempt. Cycles whose valid qualifier is low are skipped entirely, so the source may pause freely inside a frame.

Top module: `framed_seq_checker`

## Requirements
- R1: While reset is asserted and in the cycle after it, `match_pulse` and `miss_pulse` are low, and no check is in progress.
- R2: A cycle with `bit_valid` and `frame_start` both high begins a check. Its `bit_in` is sequence bit 0 and is compared with `PATTERN[SEQ_LEN-1]`. Bit k of the sequence is `PATTERN[SEQ_LEN-1-k]`, so the pattern is sent most significant bit first.
- R3: When all `SEQ_LEN` valid bits of a framed attempt match, `match_pulse` is high for exactly one cycle. That cycle follows the clock edge that sampled the final bit.
- R4: The first valid bit of an active attempt that differs from the expected bit raises `miss_pulse` for exactly one cycle, in the cycle after the edge that sampled it.
- R5: After a mismatch, further valid bits raise no pulse until the next valid frame start.
- R6: Valid bits that arrive with no check in progress and without `frame_start` raise no pulse, even when they equal the pattern.
- R7: A cycle with `bit_valid` low has no effect on the check, whatever `bit_in` and `frame_start` carry. The attempt resumes at the same bit position on the next valid bit.
- R8: A valid `frame_start` during an active check abandons that check and restarts at bit 0 with the accompanying bit.
- R9: After a match the block returns to idle. The next sequence is checked only after a new frame start.
- R10: `match_pulse` and `miss_pulse` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | Qualifies `bit_in` and `frame_start` for this cycle |
| frame_start | input | 1 | Marks `bit_in` as bit 0 of a candidate sequence |
| match_pulse | output | 1 | One-cycle pulse when a whole sequence matched |
| miss_pulse | output | 1 | One-cycle pulse on the first wrong bit of an attempt |

## Verification
Both pulses are registered. Each is due in the cycle that follows the rising edge sampling the deciding bit, one register stage and no more. The bench drives inputs on the falling edge and reads the pulses one nanosecond after the next rising edge. It tags each observation with the index of the bit just applied, so a pulse arriving a cycle early or late shows up as a wrong bit index. Gaps with `bit_valid` low are inserted as extra cycles, and the bench checks that no pulse appears in them.

// File: rtl/framed_seq_checker.sv
module framed_seq_checker #(
  parameter int SEQ_LEN = 100,
  parameter logic [SEQ_LEN-1:0] PATTERN = 100'hB65A_3C91_E7D2_0F48_A6B3_5C9E_4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic bit_valid,
  input  logic frame_start,
  output logic match_pulse,
  output logic miss_pulse
);
  localparam int CW = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(SEQ_LEN - 1);

  typedef enum logic {IDLE, CHECK} state_t;

  state_t             state_q;
  logic [SEQ_LEN-1:0] ref_q;
  logic [CW-1:0]      cnt_q;

  wire [SEQ_LEN-1:0] src    = frame_start ? PATTERN : ref_q;
  wire [CW-1:0]      base   = frame_start ? '0 : cnt_q;
  wire               head   = src[SEQ_LEN-1];
  wire               active = bit_valid && (frame_start || state_q == CHECK);
  wire               hit    = active && (bit_in == head);
  wire               final_bit = (base == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= IDLE;
      ref_q       <= '0;
      cnt_q       <= '0;
      match_pulse <= 1'b0;
      miss_pulse  <= 1'b0;
    end else begin
      match_pulse <= hit && final_bit;
      miss_pulse  <= active && !hit;
      if (active) begin
        if (hit && !final_bit) begin
          state_q <= CHECK;
          cnt_q   <= base + CW'(1);
          ref_q   <= src << 1;
        end else begin
          state_q <= IDLE;
          cnt_q   <= '0;
        end
      end
    end
  end

  // R10: the two results exclude each other
  p_pulses_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(match_pulse && miss_pulse));

  // R7: a skipped cycle yields no result and keeps the position
  p_gap_no_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> (!match_pulse && !miss_pulse));

  p_gap_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> ($stable(cnt_q) && $stable(state_q)));

  // R6: unframed bits in idle are ignored
  p_idle_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == IDLE && !frame_start) |=> (!match_pulse && !miss_pulse));

  // R3: a match is only reported after the last position was reached
  p_match_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_pulse) |-> ($past(bit_valid) && ($past(cnt_q) == LAST || SEQ_LEN == 1)));

  // R9: after any result the check is idle
  p_result_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_pulse || miss_pulse) |-> (state_q == IDLE || $past(frame_start)));

  generate
    if (SEQ_LEN > 1) begin : g_multi
      // R3: the match pulse lasts one cycle
      p_match_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> !match_pulse);
    end
  endgenerate
endmodule

// File: tb/framed_seq_checker_test.sv
`timescale 1ns/1ps
module framed_seq_checker_test;
  localparam int N = 100;
  localparam logic [N-1:0] PAT = 100'hB65A_3C91_E7D2_0F48_A6B3_5C9E_4;
  localparam int NV = 7;
  // flip position (-1 none), gaps inserted, expected match index, expected miss index
  localparam int FLIP [NV] = '{-1,  0,  1, 50, 98, 99, -1};
  localparam int GAPS [NV] = '{ 0,  0,  0,  0,  1,  0,  1};
  localparam int EMAT [NV] = '{99, -1, -1, -1, -1, -1, 99};
  localparam int EMIS [NV] = '{-1,  0,  1, 50, 98, 99, -1};

  logic clk = 0, rst_n = 0, bit_in = 0, bit_valid = 0, frame_start = 0;
  logic match_pulse, miss_pulse;
  int checks = 0, fails = 0;
  int mat_at, mis_at, mat_n, mis_n, gap_pulses;
  bit both_seen = 0;

  always #10 clk = ~clk;

  framed_seq_checker uut (.clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
    .frame_start(frame_start), .match_pulse(match_pulse), .miss_pulse(miss_pulse));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_obs();
    mat_at = -1; mis_at = -1; mat_n = 0; mis_n = 0; gap_pulses = 0;
  endtask

  task automatic step(input logic b, input logic v, input logic fs, input int idx);
    @(negedge clk);
    bit_in = b; bit_valid = v; frame_start = fs;
    @(posedge clk); #1;
    if (match_pulse && miss_pulse) both_seen = 1;
    if (!v && (match_pulse || miss_pulse)) gap_pulses++;
    if (match_pulse) begin mat_n++; if (v) mat_at = idx; end
    if (miss_pulse)  begin mis_n++; if (v) mis_at = idx; end
  endtask

  task automatic send(input int first, input int last, input int flip, input bit framed, input bit gaps);
    for (int i = first; i <= last; i++) begin
      step(PAT[N-1-i] ^ (i == flip), 1'b1, framed && (i == first), i);
      if (gaps && (i % 7 == 3)) step(~PAT[N-1-i], 1'b0, 1'b1, -2);
    end
    step(1'b0, 1'b0, 1'b0, -3);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!match_pulse && !miss_pulse, "R1 outputs in reset", int'(match_pulse) + int'(miss_pulse), 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check(!match_pulse && !miss_pulse, "R1 outputs after reset", int'(match_pulse) + int'(miss_pulse), 0);

    // R6: pattern without frame marker in idle
    clear_obs();
    send(0, N-1, -1, 1'b0, 1'b0);
    check(mat_n == 0 && mis_n == 0, "R6 unframed bits ignored", mat_n + mis_n, 0);

    // R2 R3 R4 R5 R7: vector table
    for (int v = 0; v < NV; v++) begin
      clear_obs();
      send(0, N-1, FLIP[v], 1'b1, GAPS[v] != 0);
      check(mat_at == EMAT[v], $sformatf("R3 match index vec%0d", v), mat_at, EMAT[v]);
      check(mis_at == EMIS[v], $sformatf("R4 R2 miss index vec%0d", v), mis_at, EMIS[v]);
      check(mat_n + mis_n == 1, $sformatf("R5 single result vec%0d", v), mat_n + mis_n, 1);
      check(gap_pulses == 0, $sformatf("R7 no pulse in gap vec%0d", v), gap_pulses, 0);
    end

    // R8: restart in the middle of a check
    clear_obs();
    send(0, 39, -1, 1'b1, 1'b0);
    send(0, N-1, -1, 1'b1, 1'b0);
    check(mat_n == 1 && mat_at == 99, "R8 restart then match", mat_at, 99);
    check(mis_n == 0, "R8 restart no miss", mis_n, 0);

    // R8: restart rescues a failed attempt
    clear_obs();
    send(0, 20, 5, 1'b1, 1'b0);
    send(0, N-1, -1, 1'b1, 1'b0);
    check(mis_n == 1 && mis_at == 5, "R4 early miss", mis_at, 5);
    check(mat_n == 1 && mat_at == 99, "R8 match after failed attempt", mat_at, 99);

    // R9: after a match, repeat of the pattern without marker is ignored
    clear_obs();
    send(0, N-1, -1, 1'b1, 1'b0);
    send(0, N-1, -1, 1'b0, 1'b0);
    check(mat_n == 1, "R9 idle after match", mat_n, 1);
    check(mis_n == 0, "R9 no miss after match", mis_n, 0);

    // R7: frame marker with valid low does not start a check
    clear_obs();
    step(PAT[N-1], 1'b0, 1'b1, -2);
    send(1, N-1, -1, 1'b0, 1'b0);
    check(mat_n == 0 && mis_n == 0, "R7 unqualified marker ignored", mat_n + mis_n, 0);

    check(!both_seen, "R10 pulses exclusive", int'(both_seen), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule